// File: doc/BRIEF.md
# Video Black-Clamp Pulse Generator

This block produces the black-level clamp gating strobes for two composite video channels and one component channel. It runs on the pixel clock. Two external line-timing pulses come in, one primary and one secondary. Each pulse goes high shortly before the horizontal sync of its video signal and low shortly after it. The block measures how long each pulse stays high. Inside the vertical blanking interval these pulses are deliberately made wider, so a long pulse tells the block that the vertical interval is in progress.

After each timing pulse falls, the block waits a programmable back-porch delay and then asserts a clamp strobe for a programmable number of clocks. A strobe is withheld in four cases:
- the pulse was wide, which marks the vertical interval;
- a composite channel has lock gating enabled and its video PLL is not locked;
- the secondary composite channel would clamp on the same input that the primary channel has selected;
- the component channel always follows the timing pulse picked by a single select bit.

There is no data stream here, so no valid/ready handshake is used. All control and status pins are plain levels. The timing-pulse and lock inputs pass through two-flop synchronizers. The control inputs are expected to be static while strobes are being generated.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset all three clamp outputs are low, and both vertical-interval flags are cleared, so the first normal pulse after reset produces a clamp.
- R2: Let E0 be the first rising clock edge at which a timing input is seen low after a high period. The clamp strobe of a channel fed by that input goes high after edge E(3+bp_dly_i), counting the two synchronizer flops and the output register. It stays high for exactly clamp_len_i clocks. With clamp_len_i = 0 no strobe is produced.
- R3: The pulse width is the number of rising edges that sampled the input high. A width greater than wide_thr_i marks the vertical interval and suppresses the strobe that follows that pulse. A width less than or equal to wide_thr_i clears the mark, and that pulse clamps normally.
- R4: The component clamp follows the primary timing pulse when comp_src_i = 0 and the secondary timing pulse when comp_src_i = 1. A pulse on the other input produces no component strobe.
- R5: When lock_gate_pri_i = 1 and lock_pri_i = 0, the primary composite clamp stays low. The same rule applies to the secondary channel with lock_gate_sec_i and lock_sec_i. When the gate bit is 0, the lock input has no effect.
- R6: When pri_sel_i equals sec_sel_i, the secondary composite clamp stays low and the primary clamp is unaffected.
- R7: The lock inputs and the lock gate bits have no effect on the component clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_pri_i | input | 1 | Primary line-timing pulse (asynchronous) |
| hv_sec_i | input | 1 | Secondary line-timing pulse (asynchronous) |
| lock_pri_i | input | 1 | Primary video PLL locked (asynchronous) |
| lock_sec_i | input | 1 | Secondary video PLL locked (asynchronous) |
| lock_gate_pri_i | input | 1 | 1: suppress the primary clamp while unlocked |
| lock_gate_sec_i | input | 1 | 1: suppress the secondary clamp while unlocked |
| comp_src_i | input | 1 | Component clamp source: 0 primary, 1 secondary |
| pri_sel_i | input | SELW | Input number selected by the primary composite channel |
| sec_sel_i | input | SELW | Input number selected by the secondary composite channel |
| wide_thr_i | input | CNTW | Widest pulse, in clocks, still treated as a normal line |
| bp_dly_i | input | CNTW | Clocks from the detected fall to the strobe start |
| clamp_len_i | input | CNTW | Strobe length in clocks |
| clamp_pri_o | output | 1 | Primary composite clamp strobe |
| clamp_sec_o | output | 1 | Secondary composite clamp strobe |
| clamp_comp_o | output | 1 | Component clamp strobe |

## Verification
The bench sweeps every back-porch delay and strobe length from 0 to 3. At each setting it sends pulses that are just under, exactly at and above the width threshold. It then measures the cycle of the first strobe and the strobe length against 3+bp_dly_i and clamp_len_i. An off-by-one in the width compare would clamp on the first wide pulse or miss the pulse exactly at the threshold. A flag that is never cleared would silence the normal line that follows a wide one. A miscounted window would move the strobe or change its length by one clock. Separate scenarios cover the following:
- choosing the wrong component source, which would clamp on the unselected pulse;
- a lock gate applied to the component channel or ignoring its gate bit, either of which would drop or keep the wrong strobe;
- applying the shared-input rule to the wrong side, which would silence the primary channel.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  // Which line-timing input feeds a channel.
  typedef enum logic {
    SRC_PRI = 1'b0,
    SRC_SEC = 1'b1
  } hv_src_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hv_i,
  input  logic [CNTW-1:0] thr_i,
  input  logic [CNTW-1:0] bp_i,
  input  logic [CNTW-1:0] len_i,
  output logic            strobe_o,
  output logic            vflag_o
);
  localparam int PW = CNTW + 1;

  logic [CNTW-1:0] wcnt;
  logic            fall;
  logic            run;
  logic [PW-1:0]   pos;
  logic [PW-1:0]   win_end;

  // Width counter: counts the high cycles and saturates at its maximum.
  assign fall = !hv_i && (wcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (hv_i) begin
      if (wcnt != '1) wcnt <= wcnt + 1'b1;
    end else begin
      wcnt <= '0;
    end
  end

  // Vertical-interval flag, updated only at the end of a pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) vflag_o <= 1'b0;
    else if (fall) vflag_o <= (wcnt > thr_i);
  end

  AST_VFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(vflag_o)); // R3

  // Strobe window: positions bp .. bp+len-1 after the fall.
  assign win_end = {1'b0, bp_i} + {1'b0, len_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      pos <= '0;
    end else if (fall) begin
      run <= (win_end != '0);
      pos <= '0;
    end else if (run) begin
      if ((pos + PW'(1)) >= win_end) run <= 1'b0;
      pos <= pos + PW'(1);
    end
  end

  assign strobe_o = run && (pos >= {1'b0, bp_i});

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (pos < win_end)); // R2
endmodule

// File: rtl/clamp_gate.sv
module clamp_gate
  import clamp_pkg::*;
#(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      strobe_i,
  input  logic [1:0]      vflag_i,
  input  logic [1:0]      lock_i,
  input  logic [1:0]      gate_en_i,
  input  logic            comp_src_i,
  input  logic [SELW-1:0] pri_sel_i,
  input  logic [SELW-1:0] sec_sel_i,
  output logic            clamp_pri_o,
  output logic            clamp_sec_o,
  output logic            clamp_comp_o
);
  logic [1:0] base_ok;
  logic [1:0] lock_ok;
  logic       shared;
  hv_src_e    csrc;

  assign csrc    = hv_src_e'(comp_src_i);
  assign base_ok = strobe_i & ~vflag_i;
  assign lock_ok = lock_i | ~gate_en_i;
  assign shared  = (pri_sel_i == sec_sel_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clamp_pri_o  <= 1'b0;
      clamp_sec_o  <= 1'b0;
      clamp_comp_o <= 1'b0;
    end else begin
      clamp_pri_o  <= base_ok[SRC_PRI] && lock_ok[SRC_PRI];
      clamp_sec_o  <= base_ok[SRC_SEC] && lock_ok[SRC_SEC] && !shared;
      clamp_comp_o <= (csrc == SRC_SEC) ? base_ok[SRC_SEC] : base_ok[SRC_PRI];
    end
  end

  AST_SHARED_SEC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_sel_i == sec_sel_i) |=> !clamp_sec_o); // R6
  AST_LOCK_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_i[0] && !lock_i[0]) |=> !clamp_pri_o); // R5
  AST_VERT_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    vflag_i[0] |=> !clamp_pri_o); // R3
  AST_COMP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_src_i && !strobe_i[0]) |=> !clamp_comp_o); // R4
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int CNTW = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hv_pri_i,
  input  logic            hv_sec_i,
  input  logic            lock_pri_i,
  input  logic            lock_sec_i,
  input  logic            lock_gate_pri_i,
  input  logic            lock_gate_sec_i,
  input  logic            comp_src_i,
  input  logic [SELW-1:0] pri_sel_i,
  input  logic [SELW-1:0] sec_sel_i,
  input  logic [CNTW-1:0] wide_thr_i,
  input  logic [CNTW-1:0] bp_dly_i,
  input  logic [CNTW-1:0] clamp_len_i,
  output logic            clamp_pri_o,
  output logic            clamp_sec_o,
  output logic            clamp_comp_o
);
  logic [NUM_SRC-1:0] hv_raw, lock_raw, hv_s, lock_s;
  logic [NUM_SRC-1:0] strobe, vflag;

  assign hv_raw   = {hv_sec_i, hv_pri_i};
  assign lock_raw = {lock_sec_i, lock_pri_i};

  sync2 #(.W(2*NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({lock_raw, hv_raw}),
    .q_o   ({lock_s, hv_s})
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pulse_timer #(.CNTW(CNTW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .hv_i     (hv_s[g]),
      .thr_i    (wide_thr_i),
      .bp_i     (bp_dly_i),
      .len_i    (clamp_len_i),
      .strobe_o (strobe[g]),
      .vflag_o  (vflag[g])
    );
  end

  clamp_gate #(.SELW(SELW)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (strobe),
    .vflag_i      (vflag),
    .lock_i       (lock_s),
    .gate_en_i    ({lock_gate_sec_i, lock_gate_pri_i}),
    .comp_src_i   (comp_src_i),
    .pri_sel_i    (pri_sel_i),
    .sec_sel_i    (sec_sel_i),
    .clamp_pri_o  (clamp_pri_o),
    .clamp_sec_o  (clamp_sec_o),
    .clamp_comp_o (clamp_comp_o)
  );

  AST_R1_RESET_LOW: assert property (@(posedge clk)
    $past(!rst_n) |-> !(clamp_pri_o || clamp_sec_o || clamp_comp_o)); // R1
  AST_COMP_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_src_i && !vflag[1] && strobe[1]) |=> clamp_comp_o); // R7
endmodule

// File: tb/clamp_pulse_gen_test.sv
module clamp_pulse_gen_test;
  localparam int CNTW = 8;
  localparam int SELW = 2;
  localparam int THR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv_pri = 1'b0, hv_sec = 1'b0;
  logic lock_pri = 1'b1, lock_sec = 1'b1;
  logic gate_pri = 1'b0, gate_sec = 1'b0;
  logic comp_src = 1'b0;
  logic [SELW-1:0] pri_sel = 2'd0, sec_sel = 2'd1;
  logic [CNTW-1:0] thr = CNTW'(THR), bp = '0, len = '0;
  logic clamp_pri, clamp_sec, clamp_comp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clamp_pulse_gen #(.CNTW(CNTW), .SELW(SELW)) uut (
    .clk(clk), .rst_n(rst_n),
    .hv_pri_i(hv_pri), .hv_sec_i(hv_sec),
    .lock_pri_i(lock_pri), .lock_sec_i(lock_sec),
    .lock_gate_pri_i(gate_pri), .lock_gate_sec_i(gate_sec),
    .comp_src_i(comp_src), .pri_sel_i(pri_sel), .sec_sel_i(sec_sel),
    .wide_thr_i(thr), .bp_dly_i(bp), .clamp_len_i(len),
    .clamp_pri_o(clamp_pri), .clamp_sec_o(clamp_sec), .clamp_comp_o(clamp_comp)
  );

  task automatic judge(input string tag, input string ch, input bit en,
                       input int first, input int cnt);
    int ef, ec;
    ec = (en && len != 0) ? int'(len) : 0;
    ef = (ec != 0) ? 3 + int'(bp) : -1;
    checks++;
    if (cnt != ec || first != ef) begin
      errors++;
      $display("FAIL %s %s: first=%0d count=%0d expected first=%0d count=%0d",
               tag, ch, first, cnt, ef, ec);
    end
  endtask

  // Drive a pulse w clocks wide on the chosen inputs, then observe each output.
  task automatic pulse(input int w, input bit on_p, input bit on_s,
                       input bit ep, input bit es, input bit ec, input string tag);
    int fp = -1, fs = -1, fc = -1;
    int np = 0, ns = 0, nc = 0;
    @(negedge clk);
    hv_pri = on_p;
    hv_sec = on_s;
    repeat (w) @(negedge clk);
    hv_pri = 1'b0;
    hv_sec = 1'b0;
    for (int i = 0; i < int'(bp) + int'(len) + 8; i++) begin
      @(negedge clk);
      if (clamp_pri)  begin np++; if (fp < 0) fp = i; end
      if (clamp_sec)  begin ns++; if (fs < 0) fs = i; end
      if (clamp_comp) begin nc++; if (fc < 0) fc = i; end
    end
    judge(tag, "pri", ep, fp, np);
    judge(tag, "sec", es, fs, ns);
    judge(tag, "comp", ec, fc, nc);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (clamp_pri || clamp_sec || clamp_comp) begin
      errors++;
      $display("FAIL R1 in reset: outputs=%b%b%b expected 000", clamp_pri, clamp_sec, clamp_comp);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (clamp_pri || clamp_sec || clamp_comp) begin
      errors++;
      $display("FAIL R1 after reset: outputs=%b%b%b expected 000", clamp_pri, clamp_sec, clamp_comp);
    end

    // R1: first normal pulse after reset clamps (flags cleared)
    bp = 8'd1; len = 8'd2;
    pulse(4, 1, 1, 1, 1, 1, "R1_first");

    // R2/R3 sweep: delay, length, and widths below, at, and above threshold
    for (int b = 0; b < 4; b++) begin
      for (int l = 0; l < 4; l++) begin
        bp = CNTW'(b); len = CNTW'(l);
        pulse(3, 1, 1, 1, 1, 1, "R2_timing");
        pulse(THR, 1, 1, 1, 1, 1, "R3_at_thr");
        pulse(THR + 1, 1, 1, 0, 0, 0, "R3_wide");
        pulse(THR + 7, 1, 1, 0, 0, 0, "R3_wider");
        pulse(5, 1, 1, 1, 1, 1, "R3_restore");
      end
    end

    bp = 8'd2; len = 8'd3;
    // R4 component source select
    comp_src = 1'b1;
    pulse(4, 0, 1, 0, 1, 1, "R4_sec_src");
    pulse(4, 1, 0, 1, 0, 0, "R4_sec_src_pri_pulse");
    comp_src = 1'b0;
    pulse(4, 0, 1, 0, 1, 0, "R4_pri_src_sec_pulse");
    pulse(4, 1, 0, 1, 0, 1, "R4_pri_src");

    // R5 / R7 lock gating
    gate_pri = 1'b1; lock_pri = 1'b0;
    pulse(4, 1, 1, 0, 1, 1, "R5_R7_pri_unlocked");
    gate_pri = 1'b0;
    pulse(4, 1, 1, 1, 1, 1, "R5_pri_gate_off");
    lock_pri = 1'b1;
    gate_sec = 1'b1; lock_sec = 1'b0; comp_src = 1'b1;
    pulse(4, 1, 1, 1, 0, 1, "R5_R7_sec_unlocked");
    lock_sec = 1'b1;
    pulse(4, 1, 1, 1, 1, 1, "R5_sec_locked");
    gate_sec = 1'b0; comp_src = 1'b0;

    // R6 shared input
    pri_sel = 2'd2; sec_sel = 2'd2;
    pulse(4, 1, 1, 1, 0, 1, "R6_shared");
    sec_sel = 2'd3;
    pulse(4, 1, 1, 1, 1, 1, "R6_distinct");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule